// File: doc/BRIEF.md
# Partial Reconfiguration Session Controller

This block is the host-facing control point for one partial-reconfiguration session at a time. A host drives a simple register port with 64-bit words. It takes the engine through a fixed order of steps: request and see acknowledged an engine reset, wait for the busy flag to drop, pick a target region, open a session, write image words, announce the end of the data, then poll until hardware has released the session. Image words leave the block on a valid/ready stream toward a separate data queue.

The fabric-side loader is outside this block. It reports through a one-cycle `cfg_done` pulse that carries a 3-bit fault code. Fault conditions are kept in sticky flags, and the host clears them by writing ones. The busy flag in the status register stays high while a session is open or any flag is set. A fixed 128-bit interface identifier can be read back through two registers.

Register word offsets: control 0x08, status 0x10, data 0x18, error 0x20, identifier low 0xA8, identifier high 0xB0.

Top module: `prc_engine`

## Requirements
- R1: After reset every register reads zero except the identifier pair, no session is open, `push_valid` is 0 and `cfg_region` is 0.
- R2: Writing control bit 0 as 1 stores a reset request, and control bit 0 reads it back. Control bit 4 reads 1 from the cycle after the request is stored until the cycle after it is cleared. While the request is held, any session is closed and a held data word is dropped. The error flags are kept, and writes with start set are refused.
- R3: Control bits 9:7 hold the region number and drive `cfg_region`. A control write updates them only when no session is open.
- R4: A control write with bit 12 set, made while idle and with no reset request stored, opens a session. Control bit 12 reads 1 until release. A control write with bit 13 set during the data phase enters the finishing phase, and bit 13 reads 1 there. Release happens on a `cfg_done` cycle in the finishing phase once no data word is held. After release, bits 12 and 13 both read 0.
- R5: A write to offset 0x18 during the data phase is accepted when no word is held or `push_ready` is high. Its low 32 bits are then offered on `push_data` with `push_valid` from the next cycle. The word stays valid and stable until `push_ready` is seen high.
- R6: Status bit 16 reads 1 exactly while a session is open or any error flag is set. All other status bits read 0.
- R7: Error flags are bit 0 operation fault, bit 1 CRC fault, bit 2 incompatible image, bit 3 protocol violation and bit 4 overflow. A write to offset 0x20 clears each flag written as 1. A flag being set in the same cycle wins over its clear.
- R8: On release, `cfg_err` bits 0, 1 and 2 are ORed into error bits 0, 1 and 2. A `cfg_done` pulse outside the finishing phase has no effect.
- R9: A data write outside the data phase, or a control write with bit 13 set outside the data phase, sets error bit 3 and pushes nothing.
- R10: A data write during the data phase while a word is held and `push_ready` is low is dropped and sets error bit 4. The held word is unchanged.
- R11: Offsets 0xA8 and 0xB0 return the ID_LO and ID_HI parameters and ignore writes. Offset 0x18 and every undecoded offset read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Write byte offset |
| bus_wdata | input | 64 | Write data |
| bus_raddr | input | 8 | Read byte offset |
| bus_rdata | output | 64 | Read data, combinational from `bus_raddr` |
| push_valid | output | 1 | Image word available |
| push_ready | input | 1 | Queue accepts the word this cycle |
| push_data | output | 32 | Image word |
| cfg_region | output | 3 | Selected region |
| cfg_session | output | 1 | Session open |
| cfg_done | input | 1 | Loader finished pulse |
| cfg_err | input | 3 | Loader fault code, sampled with `cfg_done` |

## Verification
The assertions assume that `cfg_err` matters only in a `cfg_done` cycle. They also assume that `push_ready` may change freely but is only acted on while `push_valid` is high, and that at most one register write arrives per cycle, which the single write port already guarantees. The stimulus keeps to these assumptions: it drives one write per step, drives `cfg_done` as isolated pulses (including pulses in the wrong phase), and holds `push_ready` low for stretches to create back-pressure and overflow. A long pseudo-random phase then mixes every offset with random readiness and completion pulses while the bench model tracks the outcome cycle by cycle.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int ADDR_W = 8;
  localparam int REG_W  = 64;
  localparam int ERR_W  = 5;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_ERR   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_ID_LO = 8'hA8;
  localparam logic [ADDR_W-1:0] OFS_ID_HI = 8'hB0;

  localparam int B_RSTREQ = 0;
  localparam int B_RSTACK = 4;
  localparam int B_REGION = 7;
  localparam int B_START  = 12;
  localparam int B_FINISH = 13;
  localparam int B_BUSY   = 16;

  localparam int E_OPER  = 0;
  localparam int E_PROTO = 3;
  localparam int E_OVFL  = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_WAIT = 2'd2
  } prc_state_e;
endpackage

// File: rtl/prc_fsm.sv
module prc_fsm
  import prc_pkg::*;
#(
  parameter int REGION_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_we,
  input  logic                wr_rst,
  input  logic                wr_start,
  input  logic                wr_finish,
  input  logic [REGION_W-1:0] wr_region,
  input  logic                hold_empty,
  input  logic                cfg_done,
  output prc_state_e          state_q,
  output logic                rst_req_q,
  output logic                rst_ack_q,
  output logic [REGION_W-1:0] region_q,
  output logic                flush,
  output logic                release_o,
  output logic                finish_misuse
);
  prc_state_e state_d;
  logic       rst_next;

  assign rst_next      = ctrl_we ? wr_rst : rst_req_q;
  assign flush         = rst_next;
  assign release_o     = (state_q == ST_WAIT) && hold_empty && cfg_done && !rst_next;
  assign finish_misuse = ctrl_we && wr_finish && (state_q != ST_PUSH);

  always_comb begin
    state_d = state_q;
    if (rst_next) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (ctrl_we && wr_start && !rst_req_q) state_d = ST_PUSH;
        ST_PUSH: if (ctrl_we && wr_finish) state_d = ST_WAIT;
        ST_WAIT: if (release_o) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rst_req_q <= 1'b0;
      rst_ack_q <= 1'b0;
      region_q  <= '0;
    end else begin
      state_q   <= state_d;
      rst_req_q <= rst_next;
      rst_ack_q <= rst_req_q;
      if (ctrl_we && state_q == ST_IDLE) region_q <= wr_region;
    end
  end

  // R2
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ack_q |-> $past(rst_req_q));

  // R2
  req_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |-> state_q == ST_IDLE);

  // R3
  region_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(region_q));

  // R4
  release_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_WAIT && state_q == ST_IDLE && !rst_req_q) |-> $past(cfg_done));
endmodule

// File: rtl/prc_push.sv
module prc_push #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load_req,
  input  logic [WORD_W-1:0] load_data,
  input  logic              push_ready,
  output logic              push_valid,
  output logic [WORD_W-1:0] push_data,
  output logic              overflow
);
  logic take;

  assign take     = load_req && (!push_valid || push_ready);
  assign overflow = load_req && push_valid && !push_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      push_valid <= 1'b0;
      push_data  <= '0;
    end else if (flush) begin
      push_valid <= 1'b0;
    end else if (take) begin
      push_valid <= 1'b1;
      push_data  <= load_data;
    end else if (push_ready) begin
      push_valid <= 1'b0;
    end
  end

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready && !flush) |=> (push_valid && $stable(push_data)));

  // R10
  drop_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !flush) |=> $stable(push_data));
endmodule

// File: rtl/prc_errs.sv
module prc_errs #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] err_set,
  input  logic [N-1:0] err_clr,
  output logic [N-1:0] err_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          err_q[i] <= 1'b0;
      else if (err_set[i]) err_q[i] <= 1'b1;
      else if (err_clr[i]) err_q[i] <= 1'b0;
    end
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set) |=> ((err_q & $past(err_set)) == $past(err_set)));

  // R7
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_clr & ~err_set)) |=> ((err_q & $past(err_clr & ~err_set)) == '0));
endmodule

// File: rtl/prc_engine.sv
module prc_engine
  import prc_pkg::*;
#(
  parameter int          WORD_W   = 32,
  parameter int          REGION_W = 3,
  parameter int          CFGERR_W = 3,
  parameter logic [63:0] ID_LO    = 64'h5A5A_0123_4567_89AB,
  parameter logic [63:0] ID_HI    = 64'hC3C3_FEDC_BA98_7654
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  input  logic [ADDR_W-1:0]   bus_raddr,
  output logic [REG_W-1:0]    bus_rdata,
  output logic                push_valid,
  input  logic                push_ready,
  output logic [WORD_W-1:0]   push_data,
  output logic [REGION_W-1:0] cfg_region,
  output logic                cfg_session,
  input  logic                cfg_done,
  input  logic [CFGERR_W-1:0] cfg_err
);
  logic       ctrl_we, data_we, err_we;
  prc_state_e state_q;
  logic       rst_req_q, rst_ack_q, flush, release_w, finish_misuse;
  logic       load_req, overflow, busy;
  logic [ERR_W-1:0] err_set, err_clr, err_q;
  logic       unused_wbits;

  assign ctrl_we = bus_we && (bus_addr == OFS_CTRL);
  assign data_we = bus_we && (bus_addr == OFS_DATA);
  assign err_we  = bus_we && (bus_addr == OFS_ERR);
  assign unused_wbits = ^bus_wdata;

  prc_fsm #(.REGION_W(REGION_W)) fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_we      (ctrl_we),
    .wr_rst       (bus_wdata[B_RSTREQ]),
    .wr_start     (bus_wdata[B_START]),
    .wr_finish    (bus_wdata[B_FINISH]),
    .wr_region    (bus_wdata[B_REGION +: REGION_W]),
    .hold_empty   (!push_valid),
    .cfg_done     (cfg_done),
    .state_q      (state_q),
    .rst_req_q    (rst_req_q),
    .rst_ack_q    (rst_ack_q),
    .region_q     (cfg_region),
    .flush        (flush),
    .release_o    (release_w),
    .finish_misuse(finish_misuse)
  );

  assign load_req = data_we && (state_q == ST_PUSH);

  prc_push #(.WORD_W(WORD_W)) push_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .load_req  (load_req),
    .load_data (bus_wdata[WORD_W-1:0]),
    .push_ready(push_ready),
    .push_valid(push_valid),
    .push_data (push_data),
    .overflow  (overflow)
  );

  always_comb begin
    err_set = '0;
    if (release_w) err_set[E_OPER +: CFGERR_W] = cfg_err;
    err_set[E_PROTO] = finish_misuse || (data_we && state_q != ST_PUSH);
    err_set[E_OVFL]  = overflow;
  end
  assign err_clr = err_we ? bus_wdata[ERR_W-1:0] : '0;

  prc_errs #(.N(ERR_W)) errs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .err_set(err_set),
    .err_clr(err_clr),
    .err_q  (err_q)
  );

  assign cfg_session = (state_q != ST_IDLE);
  assign busy        = cfg_session || (|err_q);

  always_comb begin
    bus_rdata = '0;
    unique case (bus_raddr)
      OFS_CTRL: begin
        bus_rdata[B_RSTREQ] = rst_req_q;
        bus_rdata[B_RSTACK] = rst_ack_q;
        bus_rdata[B_REGION +: REGION_W] = cfg_region;
        bus_rdata[B_START]  = cfg_session;
        bus_rdata[B_FINISH] = (state_q == ST_WAIT);
      end
      OFS_STAT:  bus_rdata[B_BUSY] = busy;
      OFS_ERR:   bus_rdata[ERR_W-1:0] = err_q;
      OFS_ID_LO: bus_rdata = ID_LO;
      OFS_ID_HI: bus_rdata = ID_HI;
      default:   bus_rdata = '0;
    endcase
  end

  // R9
  stray_data_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !cfg_session) |=> err_q[E_PROTO]);

  // R6
  idle_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_session && err_q == '0) |-> !push_valid || $past(push_valid));
endmodule

// File: tb/prc_engine_tb_top.sv
`timescale 1ns/1ps
module prc_engine_tb_top;
  localparam logic [63:0] IDL = 64'h5A5A_0123_4567_89AB;
  localparam logic [63:0] IDH = 64'hC3C3_FEDC_BA98_7654;
  localparam logic [63:0] W_RST = 64'h1;
  localparam logic [63:0] W_GO  = 64'h1000;
  localparam logic [63:0] W_FIN = 64'h2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0, push_ready = 1'b0, cfg_done = 1'b0;
  logic [7:0] bus_addr = '0, bus_raddr = '0;
  logic [63:0] bus_wdata = '0;
  logic [2:0] cfg_err = '0;
  logic [63:0] bus_rdata;
  logic push_valid, cfg_session;
  logic [31:0] push_data;
  logic [2:0] cfg_region;

  int errors = 0, checks = 0;

  // model state
  bit m_rst, m_ack;
  int m_st;
  bit [2:0] m_reg;
  bit [4:0] m_err;
  logic [31:0] m_q[$];

  always #4 clk = ~clk;

  prc_engine dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .cfg_region(cfg_region), .cfg_session(cfg_session),
    .cfg_done(cfg_done), .cfg_err(cfg_err)
  );

  initial begin
    #(8ns * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [63:0] exp_read(input logic [7:0] a);
    logic [63:0] v = '0;
    case (a)
      8'h08: begin
        v[0] = m_rst; v[4] = m_ack; v[9:7] = m_reg;
        v[12] = (m_st != 0); v[13] = (m_st == 2);
      end
      8'h10: v[16] = (m_st != 0) || (m_err != 0);
      8'h20: v[4:0] = m_err;
      8'hA8: v = IDL;
      8'hB0: v = IDH;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [63:0] wd,
                      input logic [7:0] ra, input logic rdy, input logic dn,
                      input logic [2:0] ce, input string tag);
    bit rst_next, ctrlw, dataw, errw, rel;
    bit [4:0] set, clr;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = wd; bus_raddr = ra;
    push_ready = rdy; cfg_done = dn; cfg_err = ce;
    #1;
    chk(tag, "rdata", bus_rdata, exp_read(ra));
    chk(tag, "push_valid", {63'b0, push_valid}, {63'b0, m_q.size() > 0});
    if (m_q.size() > 0) chk(tag, "push_data", {32'b0, push_data}, {32'b0, m_q[0]});
    chk(tag, "region", {61'b0, cfg_region}, {61'b0, m_reg});
    chk(tag, "session", {63'b0, cfg_session}, {63'b0, m_st != 0});
    @(posedge clk);
    ctrlw = we && a == 8'h08;
    dataw = we && a == 8'h18;
    errw  = we && a == 8'h20;
    rst_next = ctrlw ? wd[0] : m_rst;
    set = '0;
    clr = errw ? wd[4:0] : '0;
    if (ctrlw && wd[13] && m_st != 1) set[3] = 1'b1;
    if (dataw && m_st != 1) set[3] = 1'b1;
    if (dataw && m_st == 1 && m_q.size() > 0 && !rdy) set[4] = 1'b1;
    rel = (m_st == 2) && (m_q.size() == 0) && dn && !rst_next;
    if (rel) set[2:0] = set[2:0] | ce;
    begin
      bit accept;
      accept = dataw && m_st == 1 && (m_q.size() == 0 || rdy);
      if (rdy && m_q.size() > 0) void'(m_q.pop_front());
      if (accept) m_q.push_back(wd[31:0]);
      if (rst_next) m_q.delete();
    end
    if (ctrlw && m_st == 0) m_reg = wd[9:7];
    if (rst_next) m_st = 0;
    else if (m_st == 0 && ctrlw && wd[12] && !m_rst) m_st = 1;
    else if (m_st == 1 && ctrlw && wd[13]) m_st = 2;
    else if (rel) m_st = 0;
    m_ack = m_rst;
    m_rst = rst_next;
    m_err = (m_err & ~clr) | set;
  endtask

  task automatic idle(input logic [7:0] ra, input logic rdy, input string tag);
    step(1'b0, 8'h00, '0, ra, rdy, 1'b0, 3'b0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] wd, input logic [7:0] ra,
                    input logic rdy, input string tag);
    step(1'b1, a, wd, ra, rdy, 1'b0, 3'b0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle(8'h08, 1'b0, "R1");
    idle(8'h10, 1'b0, "R1");
    idle(8'h20, 1'b0, "R1");
    // R11 identifier, write ignore, undecoded
    idle(8'hA8, 1'b0, "R11");
    wr(8'hB0, 64'hFFFF, 8'hB0, 1'b0, "R11");
    wr(8'hA8, 64'h1234, 8'hA8, 1'b0, "R11");
    idle(8'h18, 1'b0, "R11");
    idle(8'h40, 1'b0, "R11");
    // R2 handshake
    wr(8'h08, W_RST, 8'h08, 1'b0, "R2");
    idle(8'h08, 1'b0, "R2");
    wr(8'h08, W_RST | W_GO, 8'h08, 1'b0, "R2");
    idle(8'h08, 1'b0, "R2");
    wr(8'h08, 64'h0, 8'h08, 1'b0, "R2");
    idle(8'h08, 1'b0, "R2");
    idle(8'h10, 1'b0, "R2");
    // R3 region in idle
    wr(8'h08, 64'd5 << 7, 8'h08, 1'b0, "R3");
    // R4 open session
    wr(8'h08, W_GO | (64'd5 << 7), 8'h08, 1'b0, "R4");
    wr(8'h08, 64'd2 << 7, 8'h08, 1'b0, "R3");
    idle(8'h10, 1'b0, "R6");
    // R5 push with back-pressure
    wr(8'h18, 64'hDEAD_BEEF_CAFE_0001, 8'h20, 1'b0, "R5");
    idle(8'h20, 1'b0, "R5");
    idle(8'h20, 1'b0, "R5");
    // R10 overflow while held
    wr(8'h18, 64'h0000_0000_0000_0002, 8'h20, 1'b0, "R10");
    idle(8'h20, 1'b0, "R10");
    wr(8'h18, 64'h0000_0000_0000_0003, 8'h20, 1'b1, "R5");
    idle(8'h20, 1'b1, "R5");
    // R8 stray done in data phase
    step(1'b0, 8'h00, '0, 8'h20, 1'b1, 1'b1, 3'b111, "R8");
    wr(8'h08, W_FIN, 8'h08, 1'b1, "R4");
    step(1'b0, 8'h00, '0, 8'h20, 1'b1, 1'b1, 3'b101, "R8");
    idle(8'h08, 1'b1, "R4");
    idle(8'h10, 1'b1, "R6");
    // R7 clear subset
    wr(8'h20, 64'h11, 8'h20, 1'b0, "R7");
    wr(8'h20, 64'h1F, 8'h10, 1'b0, "R6");
    idle(8'h10, 1'b0, "R6");
    // R9 misuse
    wr(8'h18, 64'h77, 8'h20, 1'b1, "R9");
    wr(8'h20, 64'h08, 8'h20, 1'b0, "R9");
    wr(8'h08, W_FIN, 8'h20, 1'b0, "R9");
    wr(8'h20, 64'h1F, 8'h20, 1'b0, "R9");
    // R7 set wins over clear at release
    wr(8'h08, W_GO, 8'h08, 1'b0, "R4");
    wr(8'h08, W_FIN, 8'h08, 1'b0, "R4");
    step(1'b1, 8'h20, 64'h1F, 8'h20, 1'b0, 1'b1, 3'b010, "R7");
    idle(8'h20, 1'b0, "R7");
    wr(8'h20, 64'h1F, 8'h20, 1'b0, "R7");
    // R2 abort keeps errors, drops word
    wr(8'h08, W_GO, 8'h08, 1'b0, "R2");
    wr(8'h18, 64'hAB, 8'h08, 1'b0, "R2");
    wr(8'h18, 64'hCD, 8'h20, 1'b0, "R2");
    wr(8'h08, W_RST, 8'h08, 1'b0, "R2");
    idle(8'h20, 1'b0, "R2");
    idle(8'h10, 1'b0, "R2");
    wr(8'h08, 64'h0, 8'h08, 1'b0, "R2");
    idle(8'h08, 1'b0, "R2");
    // mixed pseudo-random phase
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [7:0] a, ra;
      logic [63:0] wd;
      r = $urandom_range(0, 11);
      case ($urandom_range(0, 5))
        0: ra = 8'h08; 1: ra = 8'h10; 2: ra = 8'h20;
        3: ra = 8'hA8; 4: ra = 8'hB0; default: ra = 8'h30;
      endcase
      wd = {$urandom(), $urandom()};
      a = 8'h00;
      if (r < 3) begin
        a = 8'h08;
        wd = wd & 64'h3380;
        if ($urandom_range(0, 9) == 0) wd[0] = 1'b1;
      end else if (r < 7) a = 8'h18;
      else if (r < 8) a = 8'h20;
      step(r < 8, a, wd, ra, 1'($urandom_range(0, 1)),
           ($urandom_range(0, 3) == 0), 3'($urandom_range(0, 7)), "R4");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule